// File: doc/BRIEF.md
# Group Interrupt Redistribution Unit

When a hardware thread context is descheduled, it may still hold a group or crowd interrupt that has been signalled but not acknowledged. This unit moves that interrupt to another thread. It finds the group descriptor that owns the context and reads that descriptor from a table over a request/response port. It then sends a redistribution notification to the event-queue router. The queue index in that notification is the descriptor's index plus an offset taken from the pending priority. Last, it clears the pending state of the context.

The pull requester holds `pull_req_i` high until `pull_ack_o` pulses. The unit samples the context's status byte, pending priority, current priority and virtual processor block/index when it accepts the request. It also samples the priority configuration at that moment. If no group or crowd exception is pending, the pull is acknowledged at once. If the table reports a lookup failure, the unit flags an error and acknowledges without a notification and without any register write.

Top module: `grp_redist_unit`

## Requirements
- R1: The status byte is encoded as kind in bits [7:6], crowd level in [5:4] and group level in [3:0]. A pull whose kind is not 2'b10 is acknowledged in the cycle after acceptance. It makes no descriptor request, no notification and no register write.
- R2: The descriptor request index is the virtual processor index when the group level g is 0. For g > 0 it is that index with its low g bits cleared, ORed with (1<<(g-1))-1.
- R3: The crowd level is mapped 0,1,2,3 to 0,1,2,4. The request block is the virtual processor block folded with the same clear-and-fill rule using the mapped level. The request crowd flag is high when the crowd level is nonzero.
- R4: The descriptor request is asserted in the cycle after acceptance. It holds its valid and fields stable until ready is seen.
- R5: In the returned descriptor word, bits [31:30] hold the priority-size code, bits [27:24] the target queue block and bits [23:0] the target queue index.
- R6: With the per-group priority enable set, the priority count is 1 << size code. Otherwise it is 1 << the 3-bit global priority field.
- R7: The notification index is the descriptor index plus (pending priority mod count), modulo 2^24. The notification block is the descriptor block.
- R8: The notification carries data 0 and the redistribute flag set. Valid and fields hold stable until ready.
- R9: In the cycle the notification is accepted, the unit pulses the register write. It writes status 0 and writes the captured current priority to the pending priority, and it pulses the interrupt-clear output.
- R10: A response with the error bit set pulses the error output in the response cycle. The pull is then acknowledged with no notification and no register write.
- R11: Busy is high from the cycle after a group pull is accepted through the register-write cycle. The acknowledge is a one-cycle pulse in the following cycle, with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pull_req_i | input | 1 | Context pull request, held until acknowledged |
| vp_blk_i | input | 4 | Virtual processor block |
| vp_idx_i | input | 24 | Virtual processor index |
| nsr_i | input | 8 | Context status byte |
| pipr_i | input | 8 | Pending priority |
| cppr_i | input | 8 | Current priority |
| grp_prio_en_i | input | 1 | Use the per-group priority size |
| cfg_prio_log_i | input | 3 | Global log2 priority count |
| pull_ack_o | output | 1 | Pull completion pulse |
| busy_o | output | 1 | Redistribution in progress |
| desc_req_valid_o | output | 1 | Descriptor read request |
| desc_req_ready_i | input | 1 | Table accepts request |
| desc_req_crowd_o | output | 1 | Request targets crowd table |
| desc_req_blk_o | output | 4 | Group block |
| desc_req_idx_o | output | 24 | Group index |
| desc_rsp_valid_i | input | 1 | Descriptor response valid |
| desc_rsp_word_i | input | 32 | Descriptor word 1 |
| desc_rsp_err_i | input | 1 | Lookup failed |
| ntf_valid_o | output | 1 | Notification valid |
| ntf_ready_i | input | 1 | Router accepts notification |
| ntf_blk_o | output | 4 | Target queue block |
| ntf_idx_o | output | 24 | Target queue index |
| ntf_data_o | output | 32 | Event data, always zero |
| ntf_redist_o | output | 1 | Skip-enqueue flag |
| reg_we_o | output | 1 | Context register write strobe |
| nsr_wdata_o | output | 8 | New status byte |
| pipr_wdata_o | output | 8 | New pending priority |
| irq_clr_o | output | 1 | Deassert the context interrupt line |
| err_o | output | 1 | Lookup failure pulse |

## Verification
Two functions share a cycle: acceptance of the notification by the router and the context register update. The bench provokes this by raising notification ready after zero, one or two wait cycles. Before raising it, the bench checks that no write strobe appears while the notification stalls. In the accepting cycle it checks that the write strobe, the cleared status, the reloaded priority and the interrupt clear are all present, and that the acknowledge follows one cycle later. A second case uses an error response, where the error flag and the end of the sequence must come without a write.

// File: rtl/grp_redist_pkg.sv
package grp_redist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_NTF,
    ST_DONE
  } rd_state_e;

  localparam logic [1:0] NSR_KIND_GRP = 2'b10;
  localparam int unsigned PSIZE_W = 2;
endpackage

// File: rtl/grp_addr_fold.sv
module grp_addr_fold #(
  parameter int unsigned W     = 24,
  parameter int unsigned LVL_W = 4
) (
  input  logic [W-1:0]     addr_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [W-1:0]     addr_o
);
  logic [W-1:0] keep, fill;

  // clear low lvl bits, set low lvl-1 bits
  always_comb begin
    keep = '1;
    fill = '0;
    for (int b = 0; b < W; b++) begin
      if (b < int'(lvl_i)) keep[b] = 1'b0;
      if (b + 1 < int'(lvl_i)) fill[b] = 1'b1;
    end
    addr_o = (addr_i & keep) | fill;
  end
endmodule

// File: rtl/grp_prio_offset.sv
module grp_prio_offset
  import grp_redist_pkg::*;
#(
  parameter int unsigned DESC_W = 32,
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned IDX_W  = 24,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned CFGP_W = 3
) (
  input  logic [DESC_W-1:0] word_i,
  input  logic [PRIO_W-1:0] pipr_i,
  input  logic              grp_prio_en_i,
  input  logic [CFGP_W-1:0] cfg_prio_log_i,
  output logic [BLK_W-1:0]  blk_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned BLK_LSB = IDX_W;
  localparam int unsigned PSZ_LSB = DESC_W - PSIZE_W;

  logic [PSIZE_W-1:0] psize;
  logic [CFGP_W-1:0]  log_cnt;
  logic [PRIO_W-1:0]  mask;
  logic [PRIO_W-1:0]  off;

  assign psize   = word_i[PSZ_LSB +: PSIZE_W];
  assign log_cnt = grp_prio_en_i ? CFGP_W'(psize) : cfg_prio_log_i;

  always_comb begin
    mask = '0;
    for (int b = 0; b < PRIO_W; b++)
      if (b < int'(log_cnt)) mask[b] = 1'b1;
  end

  assign off   = pipr_i & mask;
  assign blk_o = word_i[BLK_LSB +: BLK_W];
  assign idx_o = word_i[IDX_W-1:0] + IDX_W'(off);
endmodule

// File: rtl/grp_redist_ctrl.sv
module grp_redist_ctrl
  import grp_redist_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pull_req_i,
  input  logic grp_act_i,
  input  logic desc_req_ready_i,
  input  logic desc_rsp_valid_i,
  input  logic desc_rsp_err_i,
  input  logic ntf_ready_i,
  output logic cap_o,
  output logic rsp_take_o,
  output logic desc_req_valid_o,
  output logic ntf_valid_o,
  output logic reg_we_o,
  output logic err_o,
  output logic busy_o,
  output logic pull_ack_o
);
  rd_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d          = state_q;
    cap_o            = 1'b0;
    rsp_take_o       = 1'b0;
    desc_req_valid_o = 1'b0;
    ntf_valid_o      = 1'b0;
    reg_we_o         = 1'b0;
    err_o            = 1'b0;
    pull_ack_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (pull_req_i) begin
        cap_o   = 1'b1;
        state_d = grp_act_i ? ST_REQ : ST_DONE;
      end
      ST_REQ: begin
        desc_req_valid_o = 1'b1;
        if (desc_req_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: if (desc_rsp_valid_i) begin
        err_o      = desc_rsp_err_i;
        rsp_take_o = !desc_rsp_err_i;
        state_d    = desc_rsp_err_i ? ST_DONE : ST_NTF;
      end
      ST_NTF: begin
        ntf_valid_o = 1'b1;
        if (ntf_ready_i) begin
          reg_we_o = 1'b1;   // update lands with the accepting handshake
          state_d  = ST_DONE;
        end
      end
      ST_DONE: begin
        pull_ack_o = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy_o = (state_q == ST_REQ) || (state_q == ST_WAIT) || (state_q == ST_NTF);
endmodule

// File: rtl/grp_redist_unit.sv
module grp_redist_unit
  import grp_redist_pkg::*;
#(
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned IDX_W  = 24,
  parameter int unsigned DESC_W = 32,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned GLVL_W = 4,
  parameter int unsigned CFGP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pull_req_i,
  input  logic [BLK_W-1:0]  vp_blk_i,
  input  logic [IDX_W-1:0]  vp_idx_i,
  input  logic [PRIO_W-1:0] nsr_i,
  input  logic [PRIO_W-1:0] pipr_i,
  input  logic [PRIO_W-1:0] cppr_i,
  input  logic              grp_prio_en_i,
  input  logic [CFGP_W-1:0] cfg_prio_log_i,
  output logic              pull_ack_o,
  output logic              busy_o,
  output logic              desc_req_valid_o,
  input  logic              desc_req_ready_i,
  output logic              desc_req_crowd_o,
  output logic [BLK_W-1:0]  desc_req_blk_o,
  output logic [IDX_W-1:0]  desc_req_idx_o,
  input  logic              desc_rsp_valid_i,
  input  logic [DESC_W-1:0] desc_rsp_word_i,
  input  logic              desc_rsp_err_i,
  output logic              ntf_valid_o,
  input  logic              ntf_ready_i,
  output logic [BLK_W-1:0]  ntf_blk_o,
  output logic [IDX_W-1:0]  ntf_idx_o,
  output logic [DESC_W-1:0] ntf_data_o,
  output logic              ntf_redist_o,
  output logic              reg_we_o,
  output logic [PRIO_W-1:0] nsr_wdata_o,
  output logic [PRIO_W-1:0] pipr_wdata_o,
  output logic              irq_clr_o,
  output logic              err_o
);
  localparam int unsigned CRWD_W  = 2;
  localparam int unsigned CRWD_LSB = GLVL_W;
  localparam int unsigned KIND_LSB = PRIO_W - 2;
  localparam int unsigned CLVL_W  = CRWD_W + 1;

  logic              cap, rsp_take;
  logic              grp_act;
  logic [BLK_W-1:0]  blk_q;
  logic [IDX_W-1:0]  idx_q;
  logic [GLVL_W-1:0] glvl_q;
  logic [CRWD_W-1:0] crowd_q;
  logic [PRIO_W-1:0] pipr_q, cppr_q;
  logic              en_q;
  logic [CFGP_W-1:0] cfgp_q;
  logic [CLVL_W-1:0] clvl;
  logic [BLK_W-1:0]  tgt_blk, ntf_blk_q;
  logic [IDX_W-1:0]  tgt_idx, ntf_idx_q;

  assign grp_act = nsr_i[KIND_LSB +: 2] == NSR_KIND_GRP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= '0;
      idx_q   <= '0;
      glvl_q  <= '0;
      crowd_q <= '0;
      pipr_q  <= '0;
      cppr_q  <= '0;
      en_q    <= 1'b0;
      cfgp_q  <= '0;
    end else if (cap) begin
      blk_q   <= vp_blk_i;
      idx_q   <= vp_idx_i;
      glvl_q  <= nsr_i[GLVL_W-1:0];
      crowd_q <= nsr_i[CRWD_LSB +: CRWD_W];
      pipr_q  <= pipr_i;
      cppr_q  <= cppr_i;
      en_q    <= grp_prio_en_i;
      cfgp_q  <= cfg_prio_log_i;
    end
  end

  // crowd level 3 selects a 4-bit fold
  assign clvl = (crowd_q == 2'd3) ? CLVL_W'(4) : CLVL_W'(crowd_q);

  grp_addr_fold #(.W(IDX_W), .LVL_W(GLVL_W)) u_idx_fold (
    .addr_i(idx_q),
    .lvl_i (glvl_q),
    .addr_o(desc_req_idx_o)
  );

  grp_addr_fold #(.W(BLK_W), .LVL_W(CLVL_W)) u_blk_fold (
    .addr_i(blk_q),
    .lvl_i (clvl),
    .addr_o(desc_req_blk_o)
  );

  assign desc_req_crowd_o = |crowd_q;

  grp_prio_offset #(
    .DESC_W(DESC_W), .BLK_W(BLK_W), .IDX_W(IDX_W),
    .PRIO_W(PRIO_W), .CFGP_W(CFGP_W)
  ) u_prio (
    .word_i        (desc_rsp_word_i),
    .pipr_i        (pipr_q),
    .grp_prio_en_i (en_q),
    .cfg_prio_log_i(cfgp_q),
    .blk_o         (tgt_blk),
    .idx_o         (tgt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ntf_blk_q <= '0;
      ntf_idx_q <= '0;
    end else if (rsp_take) begin
      ntf_blk_q <= tgt_blk;
      ntf_idx_q <= tgt_idx;
    end
  end

  grp_redist_ctrl u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .pull_req_i      (pull_req_i),
    .grp_act_i       (grp_act),
    .desc_req_ready_i(desc_req_ready_i),
    .desc_rsp_valid_i(desc_rsp_valid_i),
    .desc_rsp_err_i  (desc_rsp_err_i),
    .ntf_ready_i     (ntf_ready_i),
    .cap_o           (cap),
    .rsp_take_o      (rsp_take),
    .desc_req_valid_o(desc_req_valid_o),
    .ntf_valid_o     (ntf_valid_o),
    .reg_we_o        (reg_we_o),
    .err_o           (err_o),
    .busy_o          (busy_o),
    .pull_ack_o      (pull_ack_o)
  );

  assign ntf_blk_o    = ntf_blk_q;
  assign ntf_idx_o    = ntf_idx_q;
  assign ntf_data_o   = '0;
  assign ntf_redist_o = 1'b1;
  assign nsr_wdata_o  = '0;
  assign pipr_wdata_o = cppr_q;
  assign irq_clr_o    = reg_we_o;
endmodule

// File: rtl/grp_redist_unit_chk.sv
module grp_redist_unit_chk #(
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned IDX_W  = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pull_ack_o,
  input logic             busy_o,
  input logic             desc_req_valid_o,
  input logic             desc_req_ready_i,
  input logic             desc_req_crowd_o,
  input logic [BLK_W-1:0] desc_req_blk_o,
  input logic [IDX_W-1:0] desc_req_idx_o,
  input logic             ntf_valid_o,
  input logic             ntf_ready_i,
  input logic [BLK_W-1:0] ntf_blk_o,
  input logic [IDX_W-1:0] ntf_idx_o,
  input logic             reg_we_o,
  input logic             err_o
);
  // R4
  desc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_req_valid_o && !desc_req_ready_i |=> desc_req_valid_o && $stable(desc_req_blk_o)
      && $stable(desc_req_idx_o) && $stable(desc_req_crowd_o));

  // R8
  ntf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o && !ntf_ready_i |=> ntf_valid_o && $stable(ntf_blk_o) && $stable(ntf_idx_o));

  // R10
  err_no_ntf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !ntf_valid_o && !reg_we_o);

  // R10
  err_then_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> pull_ack_o);

  // R11
  upd_then_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> pull_ack_o && !busy_o);

  // R11
  busy_ack_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && pull_ack_o));

  // R11
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_ack_o |=> !pull_ack_o);

  // R1
  one_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_req_valid_o, ntf_valid_o, pull_ack_o}));
endmodule

bind grp_redist_unit grp_redist_unit_chk #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/grp_redist_unit_bench.sv
module grp_redist_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pull_req = 1'b0;
  logic [3:0]  vp_blk = '0;
  logic [23:0] vp_idx = '0;
  logic [7:0]  nsr = '0, pipr = '0, cppr = '0;
  logic        en = 1'b0;
  logic [2:0]  cfgp = '0;
  logic        desc_req_ready = 1'b0;
  logic        desc_rsp_valid = 1'b0;
  logic [31:0] desc_rsp_word = '0;
  logic        desc_rsp_err = 1'b0;
  logic        ntf_ready = 1'b0;

  logic        pull_ack, busy, desc_req_valid, desc_req_crowd;
  logic [3:0]  desc_req_blk, ntf_blk;
  logic [23:0] desc_req_idx, ntf_idx;
  logic        ntf_valid, ntf_redist, reg_we, irq_clr, err;
  logic [31:0] ntf_data;
  logic [7:0]  nsr_wdata, pipr_wdata;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int ntf_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  grp_redist_unit u_grp_redist_unit (
    .clk_i(clk), .rst_ni(rst_n), .pull_req_i(pull_req),
    .vp_blk_i(vp_blk), .vp_idx_i(vp_idx), .nsr_i(nsr), .pipr_i(pipr), .cppr_i(cppr),
    .grp_prio_en_i(en), .cfg_prio_log_i(cfgp),
    .pull_ack_o(pull_ack), .busy_o(busy),
    .desc_req_valid_o(desc_req_valid), .desc_req_ready_i(desc_req_ready),
    .desc_req_crowd_o(desc_req_crowd), .desc_req_blk_o(desc_req_blk), .desc_req_idx_o(desc_req_idx),
    .desc_rsp_valid_i(desc_rsp_valid), .desc_rsp_word_i(desc_rsp_word), .desc_rsp_err_i(desc_rsp_err),
    .ntf_valid_o(ntf_valid), .ntf_ready_i(ntf_ready), .ntf_blk_o(ntf_blk), .ntf_idx_o(ntf_idx),
    .ntf_data_o(ntf_data), .ntf_redist_o(ntf_redist),
    .reg_we_o(reg_we), .nsr_wdata_o(nsr_wdata), .pipr_wdata_o(pipr_wdata),
    .irq_clr_o(irq_clr), .err_o(err)
  );

  always @(posedge clk) begin
    if (reg_we) we_cnt++;
    if (ntf_valid && ntf_ready) ntf_cnt++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] f_grp(input logic [23:0] idx, input int g);
    if (g == 0) return idx;
    return (idx & (24'hFFFFFF << g)) | 24'((1 << (g - 1)) - 1);
  endfunction

  function automatic logic [3:0] f_blk(input logic [3:0] blk, input int c);
    int ce = (c == 3) ? 4 : c;
    if (ce == 0) return blk;
    return (blk & (4'hF << ce)) | 4'((1 << (ce - 1)) - 1);
  endfunction

  task automatic do_pull(input logic [7:0] n, input logic [7:0] pp, input logic [7:0] cp,
                         input logic [3:0] b, input logic [23:0] ix, input logic [31:0] w,
                         input bit e, input bit pe, input logic [2:0] cf,
                         input int dd, input int dn);
    int we0, nt0, lg;
    logic [7:0] off;
    @(negedge clk);
    nsr = n; pipr = pp; cppr = cp; vp_blk = b; vp_idx = ix; en = pe; cfgp = cf;
    pull_req = 1'b1;
    we0 = we_cnt; nt0 = ntf_cnt;
    @(negedge clk); #1;
    // change captured inputs: block must use sampled copies
    nsr = ~n; pipr = ~pp; cppr = ~cp; vp_blk = ~b; vp_idx = ~ix; en = ~pe; cfgp = ~cf;
    #1;
    if (n[7:6] != 2'b10) begin
      chk("R1 ack", {63'd0, pull_ack}, 64'd1);
      chk("R1 no req", {63'd0, desc_req_valid}, 64'd0);
      pull_req = 1'b0;
      @(negedge clk); #1;
      chk("R1 no write", 64'(we_cnt - we0), 64'd0);
      return;
    end
    chk("R11 busy", {63'd0, busy}, 64'd1);
    chk("R4 req valid", {63'd0, desc_req_valid}, 64'd1);
    chk("R2 grp idx", {40'd0, desc_req_idx}, {40'd0, f_grp(ix, int'(n[3:0]))});
    chk("R3 grp blk", {60'd0, desc_req_blk}, {60'd0, f_blk(b, int'(n[5:4]))});
    chk("R3 crowd flag", {63'd0, desc_req_crowd}, {63'd0, |n[5:4]});
    for (int k = 0; k < dd; k++) begin
      @(negedge clk); #1;
      chk("R4 req held", {63'd0, desc_req_valid}, 64'd1);
    end
    desc_req_ready = 1'b1;
    @(negedge clk);
    desc_req_ready = 1'b0;
    desc_rsp_valid = 1'b1; desc_rsp_word = w; desc_rsp_err = e;
    #1;
    chk("R4 req dropped", {63'd0, desc_req_valid}, 64'd0);
    chk("R10 err flag", {63'd0, err}, {63'd0, e});
    @(negedge clk);
    desc_rsp_valid = 1'b0; desc_rsp_err = 1'b0;
    #1;
    if (e) begin
      chk("R10 ack", {63'd0, pull_ack}, 64'd1);
      chk("R10 no ntf", 64'(ntf_cnt - nt0), 64'd0);
      chk("R10 no write", 64'(we_cnt - we0), 64'd0);
      pull_req = 1'b0;
      return;
    end
    lg = pe ? int'(w[31:30]) : int'(cf);
    off = pp & 8'((1 << lg) - 1);
    chk("R8 ntf valid", {63'd0, ntf_valid}, 64'd1);
    chk("R5 ntf blk", {60'd0, ntf_blk}, {60'd0, w[27:24]});
    chk("R7 ntf idx", {40'd0, ntf_idx}, {40'd0, w[23:0] + {16'd0, off}});
    chk("R8 data", {32'd0, ntf_data}, 64'd0);
    chk("R8 redist", {63'd0, ntf_redist}, 64'd1);
    for (int k = 0; k < dn; k++) begin
      @(negedge clk); #1;
      chk("R9 no early write", {62'd0, reg_we, ntf_valid}, 64'd1);
    end
    ntf_ready = 1'b1;
    #1;
    chk("R9 write", {62'd0, reg_we, irq_clr}, 64'd3);
    chk("R9 nsr", {56'd0, nsr_wdata}, 64'd0);
    chk("R9 pipr", {56'd0, pipr_wdata}, {56'd0, cp});
    chk("R11 busy at write", {63'd0, busy}, 64'd1);
    @(negedge clk);
    ntf_ready = 1'b0;
    #1;
    chk("R11 ack", {62'd0, pull_ack, busy}, 64'd2);
    pull_req = 1'b0;
  endtask

  task automatic finish_sim;
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset busy", {61'd0, busy, pull_ack, desc_req_valid}, 64'd0);
    chk("R8 reset ntf", {62'd0, ntf_valid, reg_we}, 64'd0);
    rst_n = 1'b1;
    // R1 non-group kinds
    do_pull(8'h05, 8'h10, 8'h20, 4'h3, 24'h123456, 32'h0, 1'b0, 1'b1, 3'd0, 0, 0);
    do_pull(8'h45, 8'h10, 8'h20, 4'h3, 24'h123456, 32'h0, 1'b0, 1'b1, 3'd0, 0, 0);
    do_pull(8'hF3, 8'h10, 8'h20, 4'h3, 24'h123456, 32'h0, 1'b0, 1'b1, 3'd0, 0, 0);
    // R2 group levels
    for (int g = 0; g < 16; g++)
      do_pull({4'b1000, 4'(g)}, 8'h9D, 8'h33, 4'hB, 24'hA5C3F7 ^ 24'(g * 24'h010203),
              {2'(g), 2'b00, 4'(g), 24'h00F000 + 24'(g)}, 1'b0, 1'b1, 3'd0, g % 2, g % 3);
    // R3 crowd levels
    for (int c = 0; c < 4; c++) begin
      do_pull({2'b10, 2'(c), 4'd1}, 8'h01, 8'h44, 4'b1010, 24'h000FFF, 32'h4300_0100, 1'b0, 1'b0, 3'd1, 0, 1);
      do_pull({2'b10, 2'(c), 4'd2}, 8'h02, 8'h45, 4'b0101, 24'h000FFF, 32'h4300_0100, 1'b0, 1'b0, 3'd1, 1, 0);
    end
    // R6 priority count sources
    for (int p = 0; p < 4; p++)
      do_pull(8'h83, 8'hB7, 8'h07, 4'h2, 24'h00ABCD, {2'(p), 6'h07, 24'h001000}, 1'b0, 1'b1, 3'd7, 0, 0);
    for (int cf = 0; cf < 8; cf++)
      do_pull(8'h83, 8'hB7, 8'h07, 4'h2, 24'h00ABCD, 32'hC700_1000, 1'b0, 1'b0, 3'(cf), 0, 0);
    // R7 index wrap
    do_pull(8'h81, 8'h03, 8'hFF, 4'h1, 24'h000001, 32'h8AFF_FFFF, 1'b0, 1'b1, 3'd0, 0, 0);
    // R10 lookup failures
    do_pull(8'h82, 8'h05, 8'h11, 4'h6, 24'h000321, 32'hFFFF_FFFF, 1'b1, 1'b1, 3'd2, 0, 0);
    do_pull(8'hA4, 8'h05, 8'h11, 4'h6, 24'h000321, 32'h0, 1'b1, 1'b0, 3'd2, 2, 0);
    // R9 write timing against notification stall
    for (int a = 0; a < 3; a++)
      for (int d = 0; d < 3; d++)
        do_pull(8'h92, 8'h3C, 8'(a * 16 + d), 4'h9, 24'h5A5A5A, 32'h4200_0010, 1'b0, 1'b1, 3'd0, a, d);
    repeat (2) @(negedge clk);
    finish_sim();
  end
endmodule